// File: doc/BRIEF.md
# SDRAM Device-Side Burst and Read-Latency Engine

This block is the device side of a synchronous DRAM column path. A host presents one command per rising clock edge on `cmd` with a column address on `addr`. The block keeps a mode register and uses it to run read and write bursts against a small internal word array that stands in for the cell storage. Read data is scheduled by the programmed read latency, and the output enable marks the cycles in which the device drives the shared data bus. Row handling, banks, refresh and analog timing are not part of this block.

Command encoding on `cmd`: 2'b00 no operation, 2'b01 mode load, 2'b10 read, 2'b11 write. The column is `addr[COL_W-1:0]`. A mode load takes its fields from `addr`: bits [2:0] burst code, bit [3] ignored, bits [6:4] latency code, bits [8:7] operating mode, bit [9] write-single.

Top module: `sdram_burst_core`

## Requirements
- R1: After reset the latency is 3, the burst length is 1, the operating mode is normal and write-single is off; `dOutEn` and `cfgErr` are 0.
- R2: A read (cmd 2'b10) registered at edge n with latency m drives its first beat on `dOut` and raises `dOutEn` from edge n+m-1, so the host samples valid data at edge n+m; `dOutEn` stays low before that edge.
- R3: Latency code 2 selects latency 2 and code 3 selects latency 3; any other code selects latency 3 and sets `cfgErr`.
- R4: Burst codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats; codes 4 to 7 select 1 beat and set `cfgErr`; `addr[3]` has no effect.
- R5: Beat addresses of a burst count upward from the given column and wrap inside the aligned block whose size is the burst length.
- R6: `dOutEn` stays high through the last beat of a read burst and falls at the next edge unless a later read's beats take over.
- R7: A read issued while an earlier read is pending or bursting ends the earlier one at the edge where its own first beat starts; until then the earlier beats continue.
- R8: An operating mode field other than 2'b00 sets `cfgErr`, and reads and writes are then ignored.
- R9: A write (cmd 2'b11) stores `dIn` at the given column on its own edge; with write-single 0 the following burst-length minus one edges store `dIn` at the next burst addresses, with write-single 1 only the one location is stored.
- R10: A mode load (cmd 2'b01) takes effect for commands from the next edge on, and is ignored while a read is pending, `dOutEn` is high, or a write burst still has beats to store.
- R11: A write ends any read burst and drops all pending reads (`dOutEn` is low from that edge); a read ends any write burst in progress.
- R12: `dOut` is all zeros whenever `dOutEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmd | input | 2 | Command code for this edge |
| addr | input | ADDR_W | Column address, or mode fields on a mode load |
| dIn | input | DATA_W | Write data from the host |
| dOut | output | DATA_W | Read data driven by the device |
| dOutEn | output | 1 | Device drives the data bus |
| cfgErr | output | 1 | Programmed mode holds a reserved value |

## Verification
The bench builds the block with a 16-word array (COL_W = 4) and 16-bit data, so an 8-beat burst spans half the array and wrapping at both burst boundaries happens often under random traffic. The small array also makes random reads land on recently written words, which exposes wrong burst addresses and stale write-single behaviour. Random mode loads mix both latencies, all burst codes, write-single and the occasional reserved field, so overlapping reads, interrupted bursts and rejected loads arise across every latency and length pairing.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_LOAD  = 2'b01,
    CMD_READ  = 2'b10,
    CMD_WRITE = 2'b11
  } sbcCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store dIn at wrAddr this edge
    logic beatEn;  // drive a read beat from rdAddr this edge
  } sbcStrobe_t;

  localparam int MODE_BITS = 10;

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  output sbcStrobe_t        stb,
  output logic [COL_W-1:0]  wrAddr,
  output logic [COL_W-1:0]  rdAddr,
  output logic              cfgErr
);

  sbcCmd_e cmdE;
  assign cmdE = sbcCmd_e'(cmd);

  // mode state
  logic       lat3;
  logic [1:0] blLog;
  logic       wrSingle;
  logic       opBad;

  // latency pipeline and burst state
  logic             p1V, p2V;
  logic [COL_W-1:0] p1Col, p2Col;
  logic             rdOn, wrOn;
  logic [2:0]       rdLeft, wrLeft;
  logic [COL_W-1:0] rdCol, wrCol;

  logic             busy, isRead, isWrite, isLoad, launch;
  logic [COL_W-1:0] col, blMask;
  logic [3:0]       blLen;
  logic [2:0]       wrLenM1;

  function automatic logic [COL_W-1:0] nextCol(input logic [COL_W-1:0] c,
                                               input logic [COL_W-1:0] m);
    nextCol = (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  assign col     = addr[COL_W-1:0];
  assign busy    = p1V | p2V | rdOn | wrOn;
  assign isRead  = (cmdE == CMD_READ)  && !opBad;
  assign isWrite = (cmdE == CMD_WRITE) && !opBad;
  assign isLoad  = (cmdE == CMD_LOAD)  && !busy;
  assign launch  = p1V && !isWrite;
  assign blLen   = 4'd1 << blLog;
  assign blMask  = COL_W'(blLen - 4'd1);
  assign wrLenM1 = wrSingle ? 3'd0 : 3'(blLen - 4'd1);

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lat3     <= 1'b1;
      blLog    <= 2'd0;
      wrSingle <= 1'b0;
      opBad    <= 1'b0;
      cfgErr   <= 1'b0;
    end else if (isLoad) begin
      lat3     <= (addr[6:4] != 3'd2);
      blLog    <= addr[2] ? 2'd0 : addr[1:0];
      wrSingle <= addr[9];
      opBad    <= (addr[8:7] != 2'b00);
      cfgErr   <= (addr[8:7] != 2'b00) || addr[2] ||
                  !((addr[6:4] == 3'd2) || (addr[6:4] == 3'd3));
    end
  end

  // read latency pipeline: latency 3 enters at stage 2, latency 2 at stage 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      p1V <= 1'b0; p2V <= 1'b0;
      p1Col <= '0; p2Col <= '0;
    end else begin
      p2V   <= isRead && lat3;
      p2Col <= col;
      if (isRead && !lat3) begin
        p1V   <= 1'b1;
        p1Col <= col;
      end else begin
        p1V   <= p2V && !isWrite;
        p1Col <= p2Col;
      end
    end
  end

  // read burst sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOn <= 1'b0; rdLeft <= '0; rdCol <= '0;
    end else if (isWrite) begin
      rdOn <= 1'b0;
    end else if (launch) begin
      rdOn   <= 1'b1;
      rdCol  <= p1Col;
      rdLeft <= 3'(blLen - 4'd1);
    end else if (rdOn) begin
      if (rdLeft == 3'd0) begin
        rdOn <= 1'b0;
      end else begin
        rdCol  <= nextCol(rdCol, blMask);
        rdLeft <= rdLeft - 3'd1;
      end
    end
  end

  // write burst sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrOn <= 1'b0; wrLeft <= '0; wrCol <= '0;
    end else if (isRead) begin
      wrOn <= 1'b0;
    end else if (isWrite) begin
      wrOn   <= (wrLenM1 != 3'd0);
      wrLeft <= wrLenM1;
      wrCol  <= nextCol(col, blMask);
    end else if (wrOn) begin
      wrOn   <= (wrLeft != 3'd1);
      wrLeft <= wrLeft - 3'd1;
      wrCol  <= nextCol(wrCol, blMask);
    end
  end

  always_comb begin
    stb.wrEn   = isWrite || (wrOn && !isRead);
    stb.beatEn = launch || (rdOn && (rdLeft != 3'd0) && !isWrite);
    wrAddr     = isWrite ? col : wrCol;
    rdAddr     = launch ? p1Col : nextCol(rdCol, blMask);
  end

  // mode fields must not move while any burst work is outstanding
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({lat3, blLog, wrSingle, opBad}));

  // a reserved operating mode never carries burst activity
  p_no_burst_resv_r8: assert property (@(posedge clk) disable iff (!rstN)
    opBad |-> !busy);

  // write-single never leaves a write burst running
  p_single_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isWrite && wrSingle) |=> !wrOn);

  // latency 2: first beat is launched on the very next edge unless a write cancels it
  p_lat2_onset_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !lat3) |=> ((cmdE == CMD_WRITE) || stb.beatEn));

endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbcStrobe_t        stb,
  input  logic [COL_W-1:0]  wrAddr,
  input  logic [COL_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (stb.wrEn) begin
      cells[wrAddr] <= dIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut   <= '0;
      dOutEn <= 1'b0;
    end else begin
      dOutEn <= stb.beatEn;
      dOut   <= stb.beatEn ? cells[rdAddr] : '0;
    end
  end

  // bus is quiet whenever the driver is off
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !dOutEn |-> (dOut == '0));

endmodule

// File: rtl/sdram_burst_core.sv
module sdram_burst_core
  import sbc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              cfgErr
);

  sbcStrobe_t       stb;
  logic [COL_W-1:0] wrAddr, rdAddr;

  initial begin
    if (ADDR_W < MODE_BITS || COL_W < 3 || COL_W > ADDR_W)
      $error("sdram_burst_core: unsupported address widths");
  end

  sbc_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .addr   (addr),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .cfgErr (cfgErr)
  );

  sbc_datapath #(.DATA_W(DATA_W), .COL_W(COL_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .dIn    (dIn),
    .dOut   (dOut),
    .dOutEn (dOutEn)
  );

endmodule

// File: tb/sdram_burst_core_tb.sv
module sdram_burst_core_tb;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int COL_W  = 4;
  localparam int DEPTH  = 1 << COL_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        cmd = 2'b00;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic              dOutEn;
  logic              cfgErr;

  always #2.5 clk = ~clk;

  sdram_burst_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_W(COL_W)) u_dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(addr), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn), .cfgErr(cfgErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [DATA_W-1:0] mMem [DEPTH];
  bit  sV [32];
  int  sA [32];
  int  cyc = 0;
  int  mLat = 3, mBl = 1;
  bit  mSingle = 0, mOpBad = 0, mErr = 0;
  int  wRem = 0, wAddr = 0;

  function automatic int wrapNext(int a, int bl);
    return (a & ~(bl - 1)) | ((a + 1) & (bl - 1));
  endfunction

  function automatic logic [ADDR_W-1:0] modeWord(int bc, int lc, int op, bit ws);
    return ADDR_W'((int'(ws) << 9) | (op << 7) | (lc << 4) | bc);
  endfunction

  task automatic step(input logic [1:0] c, input int a, input logic [DATA_W-1:0] d,
                      input string tag);
    bit busy;
    bit expEn;
    logic [DATA_W-1:0] expD;
    int colv;
    cmd = c; addr = ADDR_W'(a); dIn = d;
    colv = a % DEPTH;
    @(posedge clk);
    busy = (wRem > 0) || sV[(cyc - 1) & 31];
    for (int k = 0; k <= 10; k++) if (sV[(cyc + k) & 31]) busy = 1;
    if (c == 2'b01 && !busy) begin
      int lc, bc;
      lc = (a >> 4) & 7;
      bc = a & 7;
      mLat    = (lc == 2) ? 2 : 3;
      mBl     = (bc < 4) ? (1 << bc) : 1;
      mSingle = (a >> 9) & 1;
      mOpBad  = ((a >> 7) & 3) != 0;
      mErr    = mOpBad || (bc >= 4) || !(lc == 2 || lc == 3);
    end
    if (c == 2'b10 && !mOpBad) begin
      int s, p;
      s = cyc + mLat - 1;
      for (int k = 0; k <= 12; k++) sV[(s + k) & 31] = 0;
      p = colv;
      for (int i = 0; i < mBl; i++) begin
        sV[(s + i) & 31] = 1;
        sA[(s + i) & 31] = p;
        p = wrapNext(p, mBl);
      end
      wRem = 0;
    end
    if (c == 2'b11 && !mOpBad)
      for (int k = 0; k <= 12; k++) sV[(cyc + k) & 31] = 0;
    expEn = sV[cyc & 31];
    expD  = expEn ? mMem[sA[cyc & 31]] : '0;
    if (c == 2'b11 && !mOpBad) begin
      mMem[colv] = d;
      wRem  = (mSingle ? 1 : mBl) - 1;
      wAddr = wrapNext(colv, mBl);
    end else if (c != 2'b10 && wRem > 0) begin
      mMem[wAddr] = d;
      wAddr = wrapNext(wAddr, mBl);
      wRem--;
    end
    sV[(cyc - 1) & 31] = 0;
    cyc++;
    @(negedge clk);
    checks++;
    if (dOutEn !== expEn || dOut !== expD || cfgErr !== mErr) begin
      errors++;
      $display("FAIL %s cyc=%0d: en/data/err actual %0b/%h/%0b expected %0b/%h/%0b",
               tag, cyc - 1, dOutEn, dOut, cfgErr, expEn, expD, mErr);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 0, DATA_W'($urandom), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    for (int i = 0; i < 32; i++) begin sV[i] = 0; sA[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (dOutEn !== 1'b0 || dOut !== '0 || cfgErr !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: en/data/err actual %0b/%h/%0b expected 0/0000/0",
               dOutEn, dOut, cfgErr);
    end

    // R1 / R2: default latency 3, single beat
    step(2'b11, 5, 16'hA5A5, "R9");
    idle(2, "R9");
    step(2'b10, 5, 0, "R1");
    idle(4, "R2");

    // R10 / R9 / R5: latency 2, burst 4, write burst then wrapping read
    step(2'b01, modeWord(2, 2, 0, 0), 0, "R10");
    step(2'b11, 6, 16'h1111, "R9");
    step(2'b00, 0, 16'h2222, "R9");
    step(2'b00, 0, 16'h3333, "R9");
    step(2'b00, 0, 16'h4444, "R9");
    step(2'b10, 6, 0, "R5");
    idle(6, "R6");

    // R7: latency 3, burst 8, second read during first burst
    step(2'b01, modeWord(3, 3, 0, 0), 0, "R10");
    step(2'b10, 3, 0, "R7");
    idle(3, "R7");
    step(2'b10, 9, 0, "R7");
    idle(12, "R7");

    // R10: mode load while busy is ignored
    step(2'b10, 1, 0, "R10");
    step(2'b01, modeWord(6, 1, 1, 1), 0, "R10");
    idle(12, "R10");

    // R9: write-single with burst 4
    step(2'b01, modeWord(2, 2, 0, 1), 0, "R9");
    step(2'b11, 0, 16'hBEEF, "R9");
    step(2'b00, 0, 16'hDEAD, "R9");
    step(2'b00, 0, 16'hDEAD, "R9");
    step(2'b00, 0, 16'hDEAD, "R9");
    step(2'b10, 0, 0, "R9");
    idle(6, "R9");

    // R4: reserved burst code, bit 3 ignored
    step(2'b01, modeWord(13, 2, 0, 0), 0, "R4");
    step(2'b10, 6, 0, "R4");
    idle(4, "R4");
    step(2'b01, modeWord(9, 2, 0, 0), 0, "R4");
    step(2'b10, 6, 0, "R4");
    idle(4, "R4");

    // R3: reserved latency code
    step(2'b01, modeWord(1, 5, 0, 0), 0, "R3");
    step(2'b10, 7, 0, "R3");
    idle(5, "R3");

    // R8: reserved operating mode blocks reads and writes
    step(2'b01, modeWord(1, 2, 2, 0), 0, "R8");
    step(2'b11, 8, 16'h7777, "R8");
    step(2'b10, 8, 0, "R8");
    idle(4, "R8");
    step(2'b01, modeWord(0, 2, 0, 0), 0, "R8");
    step(2'b10, 8, 0, "R8");
    idle(3, "R8");

    // R11: write ends a read burst; read ends a write burst
    step(2'b01, modeWord(3, 2, 0, 0), 0, "R11");
    step(2'b10, 0, 0, "R11");
    idle(3, "R11");
    step(2'b11, 12, 16'h0C0C, "R11");
    step(2'b00, 0, 16'h0D0D, "R11");
    step(2'b10, 12, 0, "R11");
    idle(12, "R11");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r, bc, lc, op;
      r = $urandom % 16;
      if (r < 7)       step(2'b00, 0, DATA_W'($urandom), "R12");
      else if (r < 10) step(2'b10, $urandom % DEPTH, 0, "R2");
      else if (r < 13) step(2'b11, $urandom % DEPTH, DATA_W'($urandom), "R9");
      else begin
        bc = ($urandom % 8 == 0) ? 4 + $urandom % 4 : $urandom % 4;
        lc = ($urandom % 8 == 0) ? $urandom % 8 : 2 + $urandom % 2;
        op = ($urandom % 16 == 0) ? 1 + $urandom % 3 : 0;
        step(2'b01, modeWord(bc, lc, op, 1'($urandom)), 0, "R10");
      end
    end
    idle(12, "R6");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule